// File: doc/BRIEF.md
# Quasi-Resonant Gate Turn-On/Turn-Off Sequencer

This block decides, cycle by cycle, whether the primary power switch of a quasi-resonant flyback converter is on or off during normal (non-burst) operation. After each turn-off it waits out a ringing-suppression window. The window is short when the ringing was large at the moment of turn-off and long when it was small. Once the window has passed, it counts the falling zero-crossing events of the demagnetisation ringing. It switches on in the valley whose count equals a load-dependent skip target, provided the zero-crossing input is below its low threshold at that moment. If no valley match occurs, a maximum off-time timer forces a turn-on so that the switching frequency cannot fall too low.

Turn-off comes from the current-sense comparator or the peak-limit comparator. Both are ignored during a leading-edge blanking window after each turn-on. The on/off state sits in a set/reset register. A burst-mode flag suppresses every turn-on. A disable input from the protection logic forces the switch off and clears every timer and the valley count. The comparator flags arrive already synchronised and one clock wide where they are events. All times are counted in clock cycles and set by parameters.

Top module: `qr_gate_seq`

## Requirements
- R1: While reset is asserted, and in the first sample after it is released, the gate output is 0 and the valley count is 0.
- R2: While the gate is off and ringing suppression has elapsed, each cycle with the zero-crossing fall flag high raises the valley count by one. The count saturates at all-ones, holds while the gate is on, and returns to 0 at every turn-on.
- R3: In the cycle the turn-off is taken, the ringing-level flag is sampled. If it is 1, zero-crossing fall flags are ignored during the RING_SHORT_CYC cycles that follow turn-off. If it is 0, they are ignored for RING_LONG_CYC cycles.
- R4: The gate turns on at the next clock edge when all of these hold in a cycle: the gate is off, burst is inactive, suppression has elapsed, the valley count equals the skip target, and the zero-crossing low flag is 1.
- R5: If no other turn-on occurs, the gate turns on after exactly MAX_OFF_CYC consecutive off cycles, counted from turn-off, from reset release, or from the end of a disable.
- R6: Trip flags are ignored during the first LEB_CYC cycles of each on-time. A trip seen in any later on-cycle turns the gate off at the next edge, so a trip held from turn-on gives an on-time of exactly LEB_CYC+1 cycles.
- R7: The peak-limit flag turns the gate off on its own, with the same blanking and timing as the current comparator flag.
- R8: No turn-on of either kind occurs while the burst flag is 1. The maximum off-time timer holds at its final value during burst, so the turn-on follows at the first edge after burst drops.
- R9: When disable is 1, the gate is 0 after the next edge and the valley count is 0. All timers are cleared, so the maximum off-time count restarts when disable drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prot_off_i | input | 1 | Protection disable: forces the gate off and clears the timers |
| zc_fall_i | input | 1 | One-cycle event: zero-crossing input fell through its low threshold |
| zc_low_i | input | 1 | Zero-crossing input is currently below its low threshold |
| ring_high_i | input | 1 | Zero-crossing input is above the ringing-level threshold |
| skip_target_i | input | CNT_W | Valley on which to turn on (load-dependent skip count) |
| cur_trip_i | input | 1 | Current-sense comparator has tripped |
| peak_trip_i | input | 1 | Peak-current limit comparator has tripped |
| burst_i | input | 1 | Burst mode active: blocks turn-on |
| gate_o | output | 1 | Gate command, 1 means switch on |
| valley_o | output | CNT_W | Current valley count |

## Verification
Some properties are checked on every cycle. No blanked trip ends an on-time. No turn-on follows a burst cycle. Disable always yields an off gate. The valley count holds through suppression and while it is neither cleared nor incremented, and the expired off-time timer stays saturated. Other behaviours only the bench scenarios can show, because they depend on exact counts and on which ring window was chosen: that the on-time equals the blanking length plus one, that the off-time equals the maximum off-time, that the valley count saturates, and that a match fires only with the low flag present. A cycle-accurate reference model in the bench is compared against both outputs through directed and random stimulus.

// File: rtl/qrs_pkg.sv
package qrs_pkg;
   // which ringing-suppression window was chosen at turn-off
   typedef enum logic {
      RING_WIN_LONG  = 1'b0,
      RING_WIN_SHORT = 1'b1
   } ring_win_e;

   function automatic int unsigned cnt_bits(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/qrs_down_timer.sv
module qrs_down_timer #(
   parameter int unsigned MAX_VAL = 8,
   localparam int unsigned W = qrs_pkg::cnt_bits(MAX_VAL)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         done
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (clr)           cnt_q <= '0;
      else if (load)          cnt_q <= load_val;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);

   // R3
   timer_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !load && !done) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/qrs_valley_cnt.sv
module qrs_valley_cnt #(
   parameter int unsigned CNT_W    = 3,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc_en,
   input  logic             pulse,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] TOP = '1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nx;
   logic             bump;

   assign bump = inc_en && pulse;

   generate
      if (SATURATE) begin : g_sat
         always_comb begin
            cnt_nx = cnt_q;
            if (bump && cnt_q != TOP) cnt_nx = cnt_q + 1'b1;
         end
      end else begin : g_wrap
         always_comb begin
            cnt_nx = cnt_q;
            if (bump) cnt_nx = cnt_q + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else          cnt_q <= cnt_nx;
   end

   assign count = cnt_q;

   // R2
   valley_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count == '0));
   // R2
   valley_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !bump) |=> $stable(count));
endmodule

// File: rtl/qrs_offtime_timer.sv
module qrs_offtime_timer #(
   parameter int unsigned MAX_OFF_CYC = 64,
   localparam int unsigned W = qrs_pkg::cnt_bits(MAX_OFF_CYC)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   output logic expired
);
   localparam logic [W-1:0] LAST = W'(MAX_OFF_CYC - 1);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt_q <= '0;
      else if (clr)                  cnt_q <= '0;
      else if (run && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
   end

   assign expired = (cnt_q == LAST);

   // R8
   offtime_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expired && !clr) |=> expired);
endmodule

// File: rtl/qr_gate_seq.sv
module qr_gate_seq #(
   parameter int unsigned CNT_W          = 3,
   parameter int unsigned LEB_CYC        = 41,
   parameter int unsigned RING_SHORT_CYC = 525,
   parameter int unsigned RING_LONG_CYC  = 5250,
   parameter int unsigned MAX_OFF_CYC    = 5251,
   parameter bit          VALLEY_SAT     = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             prot_off_i,
   input  logic             zc_fall_i,
   input  logic             zc_low_i,
   input  logic             ring_high_i,
   input  logic [CNT_W-1:0] skip_target_i,
   input  logic             cur_trip_i,
   input  logic             peak_trip_i,
   input  logic             burst_i,
   output logic             gate_o,
   output logic [CNT_W-1:0] valley_o
);
   import qrs_pkg::*;

   localparam int unsigned RING_W = cnt_bits(RING_LONG_CYC);
   localparam int unsigned LEB_W  = cnt_bits(LEB_CYC);

   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
      if (LEB_CYC < 1) begin : g_bad_leb
         $error("LEB_CYC must be at least 1");
      end
      if (RING_SHORT_CYC > RING_LONG_CYC) begin : g_bad_ring_order
         $error("RING_SHORT_CYC must not exceed RING_LONG_CYC");
      end
      if (RING_LONG_CYC >= MAX_OFF_CYC) begin : g_bad_ring_len
         $error("RING_LONG_CYC must be below MAX_OFF_CYC");
      end
   endgenerate

   logic              gate_q;
   logic              leb_done;
   logic              ring_done;
   logic              off_expired;
   logic              valley_match;
   logic              set_c;
   logic              off_c;
   ring_win_e         ring_win;
   logic [RING_W-1:0] ring_len;
   logic [CNT_W-1:0]  valley;

   assign ring_win     = ring_high_i ? RING_WIN_SHORT : RING_WIN_LONG;
   assign ring_len     = (ring_win == RING_WIN_SHORT) ? RING_W'(RING_SHORT_CYC)
                                                      : RING_W'(RING_LONG_CYC);
   assign valley_match = ring_done && (valley == skip_target_i) && zc_low_i;
   assign set_c        = !gate_q && !burst_i && (valley_match || off_expired);
   assign off_c        = gate_q && leb_done && (cur_trip_i || peak_trip_i);

   // set/reset register: disable first, then turn-off, then turn-on
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          gate_q <= 1'b0;
      else if (prot_off_i) gate_q <= 1'b0;
      else if (off_c)      gate_q <= 1'b0;
      else if (set_c)      gate_q <= 1'b1;
   end

   qrs_down_timer #(.MAX_VAL(LEB_CYC)) u_leb (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (prot_off_i),
      .load     (set_c),
      .load_val (LEB_W'(LEB_CYC)),
      .done     (leb_done)
   );

   qrs_down_timer #(.MAX_VAL(RING_LONG_CYC)) u_ring (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (prot_off_i),
      .load     (off_c),
      .load_val (ring_len),
      .done     (ring_done)
   );

   qrs_valley_cnt #(.CNT_W(CNT_W), .SATURATE(VALLEY_SAT)) u_valley (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (prot_off_i || set_c),
      .inc_en (!gate_q && ring_done),
      .pulse  (zc_fall_i),
      .count  (valley)
   );

   qrs_offtime_timer #(.MAX_OFF_CYC(MAX_OFF_CYC)) u_offt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (prot_off_i || off_c),
      .run     (!gate_q),
      .expired (off_expired)
   );

   assign gate_o   = gate_q;
   assign valley_o = valley;

   // one cycle after reset release before history-based checks apply
   logic armed_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= 1'b1;
   end

   // R6
   leb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && $fell(gate_o) && !$past(prot_off_i)) |-> $past(leb_done));
   // R8
   burst_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && $rose(gate_o)) |-> !$past(burst_i));
   // R9
   prot_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prot_off_i |=> (!gate_o && valley_o == '0));
   // R3
   ring_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate_o && !ring_done && !prot_off_i) |=> $stable(valley_o));
   // R2
   turn_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && $rose(gate_o)) |-> (valley_o == '0));
endmodule

// File: tb/tb_qr_gate_seq.sv
module tb_qr_gate_seq;
   localparam int CW   = 3;
   localparam int LEB  = 4;
   localparam int RS   = 6;
   localparam int RL   = 20;
   localparam int MOFF = 40;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          prot_off = 1'b0, zc_fall = 1'b0, zc_low = 1'b0, ring_high = 1'b0;
   logic [CW-1:0] target = 3'd3;
   logic          cur_trip = 1'b0, peak_trip = 1'b0, burst = 1'b0;
   logic          gate;
   logic [CW-1:0] valley;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit finished = 1'b0;

   // reference model state
   int m_gate, m_valley, m_leb, m_ring, m_off;

   always #4 clk = ~clk;

   qr_gate_seq #(.CNT_W(CW), .LEB_CYC(LEB), .RING_SHORT_CYC(RS),
                 .RING_LONG_CYC(RL), .MAX_OFF_CYC(MOFF)) dut (
      .clk(clk), .rst_n(rst_n), .prot_off_i(prot_off), .zc_fall_i(zc_fall),
      .zc_low_i(zc_low), .ring_high_i(ring_high), .skip_target_i(target),
      .cur_trip_i(cur_trip), .peak_trip_i(peak_trip), .burst_i(burst),
      .gate_o(gate), .valley_o(valley));

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
      end
   endtask

   function automatic void model_reset();
      m_gate = 0; m_valley = 0; m_leb = 0; m_ring = 0; m_off = 0;
   endfunction

   // next state from the requirements, using the inputs of this cycle
   function automatic void model_step();
      if (prot_off) begin
         model_reset();
      end else if (m_gate == 1) begin
         if (m_leb == 0 && (cur_trip || peak_trip)) begin
            m_gate = 0;
            m_ring = ring_high ? RS : RL;
            m_off  = 0;
         end else if (m_leb != 0) begin
            m_leb--;
         end
      end else begin
         if (!burst && ((m_ring == 0 && m_valley == int'(target) && zc_low) ||
                        m_off == MOFF - 1)) begin
            m_gate = 1; m_leb = LEB; m_valley = 0;
         end else begin
            if (m_ring != 0) m_ring--;
            else if (zc_fall && m_valley != (1 << CW) - 1) m_valley++;
            if (m_off != MOFF - 1) m_off++;
         end
      end
   endfunction

   task automatic cyc(input string tag);
      model_step();
      @(posedge clk);
      @(negedge clk);
      chk(tag, int'(gate), m_gate);
      chk(tag, int'(valley), m_valley);
   endtask

   task automatic idle_inputs();
      prot_off = 0; zc_fall = 0; zc_low = 0; ring_high = 0;
      cur_trip = 0; peak_trip = 0; burst = 0;
   endtask

   task automatic wait_gate(input int lvl, input string tag);
      for (int i = 0; i < 200 && int'(gate) != lvl; i++) cyc(tag);
   endtask

   task automatic finish_run();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      while (!finished) begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
            finish_run();
         end
      end
   end

   initial begin
      int n;
      void'($urandom(32'd2718));
      model_reset();
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", int'(gate), 0);
      chk("R1", int'(valley), 0);
      rst_n = 1'b1;
      chk("R1", int'(gate), 0);

      // R5 start-up kick by the off-time timer, then R6 blanking with trip held
      cur_trip = 1;
      wait_gate(1, "R5");
      n = 0;
      while (gate && n < 100) begin cyc("R6"); n++; end
      chk("R6", n, LEB + 1);
      cur_trip = 0;
      // R5 exact off-time with no valleys
      n = 0;
      while (!gate && n < 100) begin cyc("R5"); n++; end
      chk("R5", n, MOFF);

      // R7 peak trip alone; ring level high at turn-off selects short window (R3)
      peak_trip = 1; ring_high = 1;
      wait_gate(0, "R7");
      peak_trip = 0; ring_high = 0;
      // R3 pulses inside the short window are ignored
      zc_fall = 1;
      for (int i = 0; i < RS - 1; i++) cyc("R3");
      chk("R3", int'(valley), 0);
      zc_fall = 0; cyc("R3");
      // R4 count to target 3 with zc high, then match with zc low
      target = 3'd3;
      for (int i = 0; i < 3; i++) begin zc_fall = 1; cyc("R2"); zc_fall = 0; cyc("R2"); end
      chk("R4", int'(gate), 0);
      chk("R2", int'(valley), 3);
      zc_low = 1; cyc("R4");
      chk("R4", int'(gate), 1);
      chk("R2", int'(valley), 0);
      zc_low = 0;

      // R3 long window: low ring level at turn-off
      cur_trip = 1; wait_gate(0, "R3"); cur_trip = 0;
      zc_fall = 1;
      for (int i = 0; i < RL - 1; i++) cyc("R3");
      chk("R3", int'(valley), 0);
      // R2 saturation at all-ones
      for (int i = 0; i < 10; i++) cyc("R2");
      chk("R2", int'(valley), 7);
      zc_fall = 0;

      // R8 burst blocks turn-on; release gives turn-on at next edge
      burst = 1;
      for (int i = 0; i < MOFF + 5; i++) cyc("R8");
      chk("R8", int'(gate), 0);
      burst = 0; cyc("R8");
      chk("R8", int'(gate), 1);

      // R9 disable forces off and clears state
      prot_off = 1; cyc("R9");
      chk("R9", int'(gate), 0);
      prot_off = 0;
      n = 0;
      while (!gate && n < 100) begin cyc("R9"); n++; end
      chk("R9", n, MOFF);

      // random phase against the model
      for (int i = 0; i < 6000; i++) begin
         if (i % 150 == 0) target = CW'(1 + $urandom_range(0, 6));
         zc_fall   = ($urandom_range(0, 5) == 0);
         zc_low    = $urandom_range(0, 1);
         ring_high = $urandom_range(0, 1);
         cur_trip  = ($urandom_range(0, 4) == 0);
         peak_trip = ($urandom_range(0, 19) == 0);
         if ($urandom_range(0, 99) == 0) burst = ~burst;
         prot_off  = ($urandom_range(0, 299) == 0);
         cyc("R4");
      end
      idle_inputs();
      cyc("R1");
      finish_run();
   end
endmodule